// File: doc/BRIEF.md
# USB Data-Field CRC16 Generator and Checker

This block computes the 16-bit cyclic redundancy check that protects the data field of a USB data packet. It operates on the un-stuffed, pre-NRZI byte stream, one byte per clock. A start strobe opens a protected field and an end strobe closes it. The PID byte is never presented to it. Each byte is folded into a 16-bit remainder, least significant bit first, using the generator polynomial x^16 + x^15 + x^2 + 1 (pattern 0x8005). The remainder starts from all ones.

The operating mode is captured together with the start strobe. In generate mode the field holds only the payload. Once the field closes, the block presents the two CRC bytes to append, over two consecutive cycles. The byte order suits a byte-wide transmitter that serialises each byte LSB first, so the inverted remainder goes out on the wire MSB first. In check mode the field holds the payload followed by the two received CRC bytes. One cycle after the field closes, a single-cycle pass or fail pulse reports whether the remainder landed on the fixed residual 0x800D.

A small state machine sequences the field. States: IDLE (waiting for a start), FIELD (accumulating bytes), TX_LO (first CRC byte out), TX_HI (second CRC byte out), VERDICT (pass/fail pulse). Transitions:
- IDLE→FIELD on a start without an end.
- IDLE→TX_LO or IDLE→VERDICT on a start with an end in the same cycle.
- FIELD→TX_LO (generate) or FIELD→VERDICT (check) on an end.
- FIELD→FIELD on a new start, which re-seeds the remainder.
- TX_LO→TX_HI, then TX_HI→IDLE.
- VERDICT→IDLE.

Top module: `usb_crc16_unit`

## Requirements
- R1: A synchronous reset, active high, returns the block to IDLE. While `rst` is high and in the first cycle after it falls, `crc_valid`, `crc_ok` and `crc_err` are all 0.
- R2: `fld_start` seeds the remainder with 0xFFFF, and a byte presented in the same cycle is folded in from that seed. A `fld_start` while a field is open discards the partial remainder and begins a new field.
- R3: Each accepted byte is folded in bit 0 first. For each bit, the feedback is remainder bit 15 XOR the data bit; the remainder shifts left with a zero fill and is XORed with 0x8005 when the feedback is 1.
- R4: In generate mode (`mode_check`=0), let C be the bitwise inverse of the final remainder. The cycle after `fld_end` shows `crc_valid`=1 with `crc_byte` = C[15:8] in reversed bit order. The next cycle shows `crc_valid`=1 with C[7:0] in reversed bit order. The cycle after that shows `crc_valid`=0.
- R5: A generate-mode field with no payload (`fld_start` and `fld_end` together, `in_valid`=0) yields CRC bytes 0x00, 0x00.
- R6: In check mode (`mode_check`=1), the cycle after `fld_end` carries exactly one of `crc_ok` (remainder equals 0x800D) or `crc_err` (any other value). Both are 0 in the following cycle.
- R7: A check-mode field that holds only the two bytes 0x00, 0x00 (empty payload) yields `crc_ok`.
- R8: A check-mode field whose payload or CRC bytes have any single bit flipped yields `crc_err`.
- R9: All inputs are ignored in the TX_LO, TX_HI and VERDICT cycles. Bytes, starts and ends presented there change neither the second CRC byte nor the state that follows.
- R10: `mode_check` is sampled only with `fld_start`. Changing it inside an open field does not change how that field is closed.
- R11: Cycles inside an open field with `in_valid`=0 leave the remainder unchanged.
- R12: Bytes and `fld_end` strobes presented in IDLE without `fld_start` are ignored. They produce no CRC byte and no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_check | input | 1 | 0 = generate, 1 = check; sampled with `fld_start` |
| in_valid | input | 1 | `in_data` holds a byte of the field |
| fld_start | input | 1 | Opens a protected field (re-seeds the remainder) |
| fld_end | input | 1 | Closes the field; the byte in the same cycle, if valid, is its last |
| in_data | input | 8 | Field byte, folded in bit 0 first |
| crc_valid | output | 1 | `crc_byte` holds a CRC byte to append |
| crc_byte | output | 8 | CRC byte, first-sent byte first |
| crc_ok | output | 1 | One-cycle pulse: check passed |
| crc_err | output | 1 | One-cycle pulse: check failed |

## Verification
The bench builds the block with its default values: polynomial 0x8005, seed 0xFFFF and residual 0x800D. These are the only values that give USB-compatible CRC bytes, so every expected value is a real USB data CRC. The payload length ranges from zero to 64 bytes, which covers both empty-payload cases as well as the multi-byte carry of the remainder. Idle gaps are inserted at random inside the fields. The bench also drives restarts, a mode flip inside a field, stray bytes while in IDLE, and junk presented during the emission cycles.

// File: rtl/usb_crc16_pkg.sv
package usb_crc16_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;

    localparam logic [CRC_W-1:0] CRC16_POLY    = 16'h8005;
    localparam logic [CRC_W-1:0] CRC16_SEED    = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC16_RESIDUE = 16'h800D;

    typedef logic [CRC_W-1:0]  crc_word_t;
    typedef logic [BYTE_W-1:0] crc_byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIELD,
        ST_TX_LO,
        ST_TX_HI,
        ST_VERDICT
    } crc_state_t;

endpackage

// File: rtl/crc16_byte_fold.sv
// Folds one byte into the remainder, one serial step per data bit,
// bit 0 of the byte first, remainder MSB used as feedback.
module crc16_byte_fold
    import usb_crc16_pkg::*;
#(
    parameter int               DATA_W = BYTE_W,
    parameter logic [CRC_W-1:0] POLY   = CRC16_POLY
) (
    input  logic [CRC_W-1:0]  rem_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  rem_out
);

    localparam int STEPS = DATA_W;

    logic [CRC_W-1:0] stage [0:STEPS];
    logic [STEPS-1:0] fb;

    assign stage[0] = rem_in;

    generate
        for (genvar i = 0; i < STEPS; i++) begin : g_step
            assign fb[i]      = stage[i][CRC_W-1] ^ data_in[i];
            assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb[i] ? POLY : '0);
        end
    endgenerate

    assign rem_out = stage[STEPS];

endmodule

// File: rtl/crc16_emit_fmt.sv
// Turns a remainder into the two bytes to append: invert, reverse all
// bits, split low half first so an LSB-first serialiser sends MSB first.
module crc16_emit_fmt
    import usb_crc16_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [CRC_W-1:0]  rem,
    output logic [DATA_W-1:0] first_byte,
    output logic [DATA_W-1:0] second_byte
);

    localparam int HALF = CRC_W / 2;

    logic [CRC_W-1:0] inv;
    logic [CRC_W-1:0] rev;

    assign inv = ~rem;

    generate
        for (genvar i = 0; i < CRC_W; i++) begin : g_rev
            assign rev[i] = inv[CRC_W-1-i];
        end
    endgenerate

    assign first_byte  = rev[HALF-1:0];
    assign second_byte = rev[CRC_W-1:HALF];

endmodule

// File: rtl/crc16_seq_fsm.sv
// Field sequencer: opens and closes the protected field, steps the
// emission beats or the verdict cycle, and steers the remainder update.
module crc16_seq_fsm
    import usb_crc16_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_check,
    input  logic in_valid,
    input  logic fld_start,
    input  logic fld_end,
    output logic rem_load,
    output logic rem_seed,
    output logic rem_fold,
    output logic emit_first,
    output logic emit_second,
    output logic verdict
);

    crc_state_t state_q;
    crc_state_t state_d;
    logic       mode_q;
    logic       eff_check;
    logic       accept;
    crc_state_t close_st;

    // Field acceptance and the closing target
    always_comb begin
        accept    = ((state_q == ST_IDLE) && fld_start) || (state_q == ST_FIELD);
        eff_check = fld_start ? mode_check : mode_q;
        close_st  = eff_check ? ST_VERDICT : ST_TX_LO;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fld_start) begin
                    state_d = fld_end ? close_st : ST_FIELD;
                end
            end
            ST_FIELD: begin
                if (fld_end) begin
                    state_d = close_st;
                end
            end
            ST_TX_LO:   state_d = ST_TX_HI;
            ST_TX_HI:   state_d = ST_IDLE;
            ST_VERDICT: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept && fld_start) begin
                mode_q <= mode_check;
            end
        end
    end

    // Outputs
    always_comb begin
        rem_load    = accept;
        rem_seed    = accept && fld_start;
        rem_fold    = accept && in_valid;
        emit_first  = 1'b0;
        emit_second = 1'b0;
        verdict     = 1'b0;
        unique case (state_q)
            ST_TX_LO:   emit_first  = 1'b1;
            ST_TX_HI:   emit_second = 1'b1;
            ST_VERDICT: verdict     = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/usb_crc16_unit.sv
module usb_crc16_unit
    import usb_crc16_pkg::*;
#(
    parameter int               DATA_W  = BYTE_W,
    parameter logic [CRC_W-1:0] POLY    = CRC16_POLY,
    parameter logic [CRC_W-1:0] SEED    = CRC16_SEED,
    parameter logic [CRC_W-1:0] RESIDUE = CRC16_RESIDUE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_check,
    input  logic              in_valid,
    input  logic              fld_start,
    input  logic              fld_end,
    input  logic [DATA_W-1:0] in_data,
    output logic              crc_valid,
    output logic [DATA_W-1:0] crc_byte,
    output logic              crc_ok,
    output logic              crc_err
);

    logic             rem_load;
    logic             rem_seed;
    logic             rem_fold;
    logic             emit_first;
    logic             emit_second;
    logic             verdict;
    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] rem_base;
    logic [CRC_W-1:0] rem_folded;
    logic [CRC_W-1:0] rem_next;
    logic [DATA_W-1:0] byte_a;
    logic [DATA_W-1:0] byte_b;

    crc16_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .mode_check  (mode_check),
        .in_valid    (in_valid),
        .fld_start   (fld_start),
        .fld_end     (fld_end),
        .rem_load    (rem_load),
        .rem_seed    (rem_seed),
        .rem_fold    (rem_fold),
        .emit_first  (emit_first),
        .emit_second (emit_second),
        .verdict     (verdict)
    );

    assign rem_base = rem_seed ? SEED : rem_q;

    crc16_byte_fold #(
        .DATA_W (DATA_W),
        .POLY   (POLY)
    ) u_fold (
        .rem_in  (rem_base),
        .data_in (in_data),
        .rem_out (rem_folded)
    );

    assign rem_next = rem_fold ? rem_folded : rem_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= SEED;
        end else if (rem_load) begin
            rem_q <= rem_next;
        end
    end

    crc16_emit_fmt #(
        .DATA_W (DATA_W)
    ) u_fmt (
        .rem         (rem_q),
        .first_byte  (byte_a),
        .second_byte (byte_b)
    );

    always_comb begin
        crc_valid = emit_first || emit_second;
        crc_byte  = emit_first ? byte_a : (emit_second ? byte_b : '0);
        crc_ok    = verdict && (rem_q == RESIDUE);
        crc_err   = verdict && (rem_q != RESIDUE);
    end

endmodule

// File: rtl/usb_crc16_unit_chk.sv
module usb_crc16_unit_chk (
    input logic clk,
    input logic rst,
    input logic fld_end,
    input logic crc_valid,
    input logic crc_ok,
    input logic crc_err
);

    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!crc_valid && !crc_ok && !crc_err));

    // R4
    a_r4_pair_second: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_valid) |=> crc_valid);

    // R4
    a_r4_pair_stops: assert property (@(posedge clk) disable iff (rst)
        (crc_valid && $past(crc_valid)) |=> !crc_valid);

    // R4
    a_r4_follows_end: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_valid) |-> $past(fld_end));

    // R6
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({crc_ok, crc_err, crc_valid}));

    // R6
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (crc_ok || crc_err) |=> !(crc_ok || crc_err));

    // R6
    a_r6_follows_end: assert property (@(posedge clk) disable iff (rst)
        (crc_ok || crc_err) |-> $past(fld_end));

endmodule

bind usb_crc16_unit usb_crc16_unit_chk u_chk (.*);

// File: tb/tb_usb_crc16_unit.sv
module tb_usb_crc16_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_check;
    logic       in_valid;
    logic       fld_start;
    logic       fld_end;
    logic [7:0] in_data;
    logic       crc_valid;
    logic [7:0] crc_byte;
    logic       crc_ok;
    logic       crc_err;

    always #10 clk = ~clk;

    usb_crc16_unit dut (
        .clk(clk), .rst(rst), .mode_check(mode_check), .in_valid(in_valid),
        .fld_start(fld_start), .fld_end(fld_end), .in_data(in_data),
        .crc_valid(crc_valid), .crc_byte(crc_byte), .crc_ok(crc_ok), .crc_err(crc_err)
    );

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] pkt  [0:71];
    logic [7:0] strm [0:73];

    function automatic logic [15:0] ref_fold(input logic [15:0] r, input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic f;
            f = r[15] ^ b[i];
            r = {r[14:0], 1'b0};
            if (f) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = b[7-i];
        return o;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic e,
                         input logic [7:0] d, input logic m);
        @(negedge clk);
        in_valid = v; fld_start = s; fld_end = e; in_data = d; mode_check = m;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    // Generate-mode packet: optional aborted prefix, gaps, mode flip, junk during emission
    task automatic run_gen(input int len, input bit gaps, input bit flip,
                           input bit poke, input bit restart, input string tag);
        logic [15:0] r;
        logic [15:0] c;
        r = 16'hFFFF;
        for (int i = 0; i < len; i++) r = ref_fold(r, pkt[i]);
        c = ~r;
        if (restart) begin
            drive(1'b1, 1'b1, 1'b0, 8'h5A, 1'b0);
            drive(1'b1, 1'b0, 1'b0, 8'hC3, 1'b0);
        end
        if (len == 0) begin
            drive(1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
        end else begin
            for (int i = 0; i < len; i++) begin
                if (gaps && i > 0 && ($urandom % 3 == 0))
                    drive(1'b0, 1'b0, 1'b0, 8'hEE, flip);
                drive(1'b1, (i == 0), (i == len - 1), pkt[i], (i == 0) ? 1'b0 : flip);
            end
        end
        if (poke) drive(1'b1, 1'b1, 1'b1, 8'hA7, 1'b1); else idle();
        check({tag, " first valid"}, crc_valid, 1);
        check({tag, " first byte"}, crc_byte, rev8(c[15:8]));
        if (poke) drive(1'b1, 1'b1, 1'b0, 8'h3C, 1'b1); else idle();
        check({tag, " second valid"}, crc_valid, 1);
        check({tag, " second byte"}, crc_byte, rev8(c[7:0]));
        idle();
        check({tag, " R4 done"}, {crc_valid, crc_ok, crc_err}, 0);
    endtask

    // Check-mode packet: payload + its CRC, optional single-bit corruption
    task automatic run_chk(input int len, input int bad, input bit gaps, input string tag);
        logic [15:0] r;
        logic [15:0] c;
        int n;
        r = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            r = ref_fold(r, pkt[i]);
            strm[i] = pkt[i];
        end
        c = ~r;
        strm[len]     = rev8(c[15:8]);
        strm[len + 1] = rev8(c[7:0]);
        n = len + 2;
        if (bad >= 0) strm[bad] = strm[bad] ^ (8'h01 << ($urandom % 8));
        for (int i = 0; i < n; i++) begin
            if (gaps && i > 0 && ($urandom % 3 == 0))
                drive(1'b0, 1'b0, 1'b0, 8'h11, 1'b0);
            drive(1'b1, (i == 0), (i == n - 1), strm[i], (i == 0) ? 1'b1 : 1'b0);
        end
        idle();
        check({tag, " ok"},  crc_ok,  (bad < 0));
        check({tag, " err"}, crc_err, (bad >= 0));
        check({tag, " no bytes"}, crc_valid, 0);
        idle();
        check({tag, " R6 pulse ends"}, {crc_ok, crc_err}, 0);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4242);
        rst = 1'b1; in_valid = 0; fld_start = 0; fld_end = 0; in_data = 0; mode_check = 0;
        repeat (3) @(negedge clk);
        check("R1 in reset", {crc_valid, crc_ok, crc_err}, 0);
        rst = 1'b0;
        idle();
        check("R1 after reset", {crc_valid, crc_ok, crc_err}, 0);

        // R12: stray bytes and end strobes in IDLE
        drive(1'b1, 1'b0, 1'b0, 8'h77, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 8'h12, 1'b1);
        idle();
        check("R12 stray end", {crc_valid, crc_ok, crc_err}, 0);
        idle();
        check("R12 stray end later", {crc_valid, crc_ok, crc_err}, 0);

        // R5: empty payload in generate mode
        run_gen(0, 0, 0, 0, 0, "R5 empty gen");

        // R7: empty payload check (bytes 00 00)
        run_chk(0, -1, 0, "R7 empty chk");

        // R6: empty field in check mode has remainder 0xFFFF -> fail
        drive(1'b0, 1'b1, 1'b1, 8'h00, 1'b1);
        idle();
        check("R6 bare field err", {crc_ok, crc_err}, 2'b01);
        idle();

        // R3: fixed four-byte pattern
        for (int i = 0; i < 4; i++) pkt[i] = 8'(i);
        run_gen(4, 0, 0, 0, 0, "R3 ramp");
        run_chk(4, -1, 0, "R3 ramp chk");

        // R2: restart mid-field discards prefix
        for (int i = 0; i < 6; i++) pkt[i] = 8'hF0 + 8'(i);
        run_gen(6, 0, 0, 0, 1, "R2 restart");

        // R9: junk during emission cycles
        run_gen(6, 0, 0, 1, 0, "R9 poke");
        idle();
        check("R9 idle after poke", {crc_valid, crc_ok, crc_err}, 0);

        // R10: mode flipped inside field
        run_gen(6, 0, 1, 0, 0, "R10 flip");

        // R11: gaps inside field
        for (int i = 0; i < 16; i++) pkt[i] = 8'($urandom);
        run_gen(16, 1, 0, 0, 0, "R11 gaps gen");
        run_chk(16, -1, 1, "R11 gaps chk");

        // R8: corruption in CRC bytes
        run_chk(16, 16, 0, "R8 crc byte hit");
        run_chk(16, 17, 0, "R8 last byte hit");

        // Random mix
        for (int k = 0; k < 40; k++) begin
            int len;
            len = $urandom % 65;
            for (int i = 0; i < len; i++) pkt[i] = 8'($urandom);
            if (k % 2 == 0) run_gen(len, ($urandom % 2), 0, ($urandom % 2), 0, "R4 rand gen");
            else if ($urandom % 2) run_chk(len, -1, ($urandom % 2), "R6 rand chk good");
            else run_chk(len, int'($urandom % (len + 2)), ($urandom % 2), "R8 rand chk bad");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule